// File: doc/BRIEF.md
# I2C Slave Wake Clock Handover

This block lets a low-power I2C slave answer its address while the system oscillator is stopped. The SCL line clocks a small receiver directly. It takes the 7-bit address and the direction bit after a START, and it compares the address with the slave's own address. On a match it pulls SDA low for the acknowledge clock. It raises the wake interrupt and a switch request in the same instant. From the falling edge of the acknowledge clock it stretches SCL low.

The wake interrupt goes to the sleep logic. That logic restarts the oscillator and reports this on `osc_run_i`. On the first system-clock edge that sees the oscillator running, a registered release flag captures the pending request. The release flag then removes the request at once. The same event hands control to the sampled-mode logic. A phase code tells that logic whether to continue with a data byte coming in or a data byte going out.

SCL is released as follows:
- With buffering enabled, SCL is released as soon as the handover completes.
- Otherwise, SCL is released only after the CPU has written the direction bit. For a read, the CPU must also have loaded the data byte.
- A compatibility input forces the second behaviour even when buffering is enabled. This holds even if the oscillator was already running.

A STOP or a reset clears all handover state.

Top module: `i2c_wake_ctrl`

## Requirements
- R1: After a START, the first eight SDA values sampled on SCL rising edges are taken as a 7-bit address, most significant bit first, followed by the R/W bit. `sda_oe_o` is high from the eighth SCL falling edge to the ninth SCL falling edge only when the address equals `own_addr_i`.
- R2: On a matching address, `irq_o` and `sw_req_o` both go high at the eighth SCL rising edge, without any `clk_i` edge.
- R3: `rel_o` goes high only on a `clk_i` rising edge where `osc_run_i` is high and the request is pending. It stays low while `osc_run_i` is low.
- R4: Once `rel_o` is high, `sw_req_o` is low while `irq_o` stays high.
- R5: `phase_o` is 2'b00 until `rel_o` is high. After that it is 2'b01 for a write (R/W=0) and 2'b10 for a read (R/W=1).
- R6: After a matching address, `scl_oe_o` is high from the ninth SCL falling edge until the release condition is met.
- R7: With `buf_en_i`=1 and `compat_i`=0, `scl_oe_o` is low within two `clk_i` cycles after `rel_o` rises.
- R8: Otherwise (`buf_en_i`=0, or `compat_i`=1), SCL stays held until `txrx_set_i` is high. For a read, it also stays held until `data_loaded_i` is high. It is freed within two `clk_i` cycles after the last of these.
- R9: `compat_i`=1 makes the block behave as in R8 even with `buf_en_i`=1, including when `osc_run_i` was already high before the address.
- R10: A non-matching address produces no acknowledge, no `irq_o`, no `sw_req_o` and no SCL stretch.
- R11: A STOP (SDA rising while SCL is high) or `rst_ni` low clears `irq_o`, `sw_req_o`, `rel_o`, `phase_o` and `scl_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, running only when the oscillator is up |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr_i | input | 7 | Slave's own 7-bit address |
| osc_run_i | input | 1 | Oscillator running, reported by the sleep logic |
| buf_en_i | input | 1 | Buffered mode: release SCL on handover |
| compat_i | input | 1 | Compatibility mode: always wait for the CPU |
| txrx_set_i | input | 1 | CPU has written the transfer-direction bit |
| data_loaded_i | input | 1 | CPU has loaded the transmit data byte |
| scl_oe_o | output | 1 | Pull SCL low (open drain) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| irq_o | output | 1 | Address-match wake interrupt |
| sw_req_o | output | 1 | Switch-to-sampled-mode request |
| rel_o | output | 1 | Registered release, handover done |
| phase_o | output | 2 | Phase for the sampled-mode logic (00 idle, 01 write data, 10 read data) |

## Verification
The bench sweeps all 128 addresses against a fixed own address. A comparator off by one bit, or shifting in the wrong order, would acknowledge a neighbouring address or raise the interrupt for it. It then walks every combination of oscillator-already-running, buffering, compatibility and direction. It checks that the request falls only after the registered release rises, and never while the oscillator is off. A design that freed SCL on the wrong condition would let the master clock out a read byte before the CPU has loaded it, or would ignore compatibility mode when buffering is on. A STOP and a mid-transfer reset are checked to leave no stale interrupt or stretch.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_WR_DATA = 2'b01,
    PH_RD_DATA = 2'b10
  } phase_e;
endpackage

// File: rtl/i2c_wake_bus_cond.sv
// START/STOP detection; toggle pair gives a frame-active level with no system clock
module i2c_wake_bus_cond (
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic in_frame_o
);
  logic start_tog_q, stop_tog_q;

  always_ff @(negedge sda_i or negedge rst_ni) begin
    if (!rst_ni)    start_tog_q <= 1'b0;
    else if (scl_i) start_tog_q <= ~stop_tog_q;
  end

  always_ff @(posedge sda_i or negedge rst_ni) begin
    if (!rst_ni)    stop_tog_q <= 1'b0;
    else if (scl_i) stop_tog_q <= start_tog_q;
  end

  assign in_frame_o = start_tog_q ^ stop_tog_q;
endmodule

// File: rtl/i2c_wake_addr_rx.sv
// SCL-clocked address receiver, ACK driver and stretch flag
module i2c_wake_addr_rx #(
  parameter int ADDR_W = 7
) (
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              frame_rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              match_o,
  output logic              rw_o,
  output logic              ack_oe_o,
  output logic              hold_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [ADDR_W-1:0] shreg_q;
  logic              done_q, match_q, rw_q;
  logic              ack_q, hold_q;

  always_ff @(posedge scl_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      rw_q      <= 1'b0;
    end else if (!done_q) begin
      if (bit_cnt_q == LAST_BIT) begin
        done_q  <= 1'b1;
        rw_q    <= sda_i;
        match_q <= (shreg_q == own_addr_i);
      end else begin
        shreg_q   <= {shreg_q[ADDR_W-2:0], sda_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  // ACK on the ninth clock, then stretch from its falling edge
  always_ff @(negedge scl_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) begin
      ack_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (match_q && !ack_q && !hold_q) begin
      ack_q <= 1'b1;
    end else if (ack_q) begin
      ack_q  <= 1'b0;
      hold_q <= 1'b1;
    end
  end

  assign match_o  = match_q;
  assign rw_o     = rw_q;
  assign ack_oe_o = ack_q;
  assign hold_o   = hold_q;

  AST_NO_LATE_MATCH: assert property (@(posedge scl_i) disable iff (!frame_rst_ni)
    (done_q && !match_q) |=> !match_q); // R10

  AST_HOLD_AFTER_ACK: assert property (@(negedge scl_i) disable iff (!frame_rst_ni)
    (!hold_q && !ack_q) |=> !hold_q); // R6
endmodule

// File: rtl/i2c_wake_handover.sv
// System-clock side: registered release and SCL free decision
module i2c_wake_handover
  import i2c_wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       frame_rst_ni,
  input  logic       match_i,
  input  logic       rw_i,
  input  logic       hold_i,
  input  logic       osc_run_i,
  input  logic       buf_en_i,
  input  logic       compat_i,
  input  logic       txrx_set_i,
  input  logic       data_loaded_i,
  output logic       sw_req_o,
  output logic       rel_o,
  output logic [1:0] phase_o,
  output logic       scl_oe_o
);
  logic   rel_q, free_q, buf_eff, cpu_ok, free_set;
  phase_e phase;

  // request set by the match, dropped as soon as its registered copy is up
  assign sw_req_o = match_i & ~rel_q;

  always_ff @(posedge clk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni)              rel_q <= 1'b0;
    else if (sw_req_o && osc_run_i) rel_q <= 1'b1;
  end

  assign buf_eff  = buf_en_i & ~compat_i;
  assign cpu_ok   = txrx_set_i & (~rw_i | data_loaded_i);
  assign free_set = rel_q & (buf_eff | cpu_ok);

  always_ff @(posedge clk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) free_q <= 1'b0;
    else if (free_set) free_q <= 1'b1;
  end

  always_comb begin
    phase = PH_IDLE;
    if (rel_q) phase = rw_i ? PH_RD_DATA : PH_WR_DATA;
  end

  assign rel_o    = rel_q;
  assign phase_o  = phase;
  assign scl_oe_o = hold_i & ~free_q;

  AST_REL_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!frame_rst_ni)
    $rose(rel_q) |-> $past(osc_run_i)); // R3

  AST_REL_FROM_REQ: assert property (@(posedge clk_i) disable iff (!frame_rst_ni)
    $rose(rel_q) |-> $past(sw_req_o)); // R4

  AST_FREE_AFTER_REL: assert property (@(posedge clk_i) disable iff (!frame_rst_ni)
    $rose(free_q) |-> $past(rel_q)); // R7

  AST_FREE_NEEDS_CPU: assert property (@(posedge clk_i) disable iff (!frame_rst_ni)
    ($rose(free_q) && !$past(buf_eff)) |-> $past(txrx_set_i)); // R8
endmodule

// File: rtl/i2c_wake_ctrl.sv
module i2c_wake_ctrl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              osc_run_i,
  input  logic              buf_en_i,
  input  logic              compat_i,
  input  logic              txrx_set_i,
  input  logic              data_loaded_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o,
  output logic              sw_req_o,
  output logic              rel_o,
  output logic [1:0]        phase_o
);
  logic in_frame, frame_rst_n;
  logic match, rw, hold;

  i2c_wake_bus_cond u_cond (
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .in_frame_o(in_frame)
  );

  // all handover state lives only between START and STOP
  assign frame_rst_n = rst_ni & in_frame;

  i2c_wake_addr_rx #(.ADDR_W(ADDR_W)) u_rx (
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .frame_rst_ni(frame_rst_n),
    .own_addr_i  (own_addr_i),
    .match_o     (match),
    .rw_o        (rw),
    .ack_oe_o    (sda_oe_o),
    .hold_o      (hold)
  );

  i2c_wake_handover u_ho (
    .clk_i        (clk_i),
    .frame_rst_ni (frame_rst_n),
    .match_i      (match),
    .rw_i         (rw),
    .hold_i       (hold),
    .osc_run_i    (osc_run_i),
    .buf_en_i     (buf_en_i),
    .compat_i     (compat_i),
    .txrx_set_i   (txrx_set_i),
    .data_loaded_i(data_loaded_i),
    .sw_req_o     (sw_req_o),
    .rel_o        (rel_o),
    .phase_o      (phase_o),
    .scl_oe_o     (scl_oe_o)
  );

  assign irq_o = match;

  AST_REQ_IMPLIES_IRQ: assert property (@(posedge clk_i) disable iff (!frame_rst_n)
    sw_req_o |-> irq_o); // R2
endmodule

// File: tb/tb_i2c_wake_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_wake_ctrl;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic osc_run = 1'b0, buf_en = 1'b0, compat = 1'b0, txrx = 1'b0, dl = 1'b0;
  logic scl_oe, sda_oe, irq, sw_req, rel;
  logic [1:0] phase;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_wake_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .own_addr_i(OWN), .osc_run_i(osc_run), .buf_en_i(buf_en), .compat_i(compat),
    .txrx_set_i(txrx), .data_loaded_i(dl), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .irq_o(irq), .sw_req_o(sw_req), .rel_o(rel), .phase_o(phase)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; m_scl = 1'b1; #40;
    m_sda = 1'b0; #40;
    m_scl = 1'b0; #20;
  endtask

  task automatic i2c_bit(input logic b);
    m_sda = b; #20;
    m_scl = 1'b1; #40;
    m_scl = 1'b0; #20;
  endtask

  task automatic i2c_ack(output logic a);
    m_sda = 1'b1; #20;
    m_scl = 1'b1; #20;
    a = ~sda_bus; #20;
    m_scl = 1'b0; #20;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; #20;
    m_scl = 1'b1;
    wait (scl_bus === 1'b1);
    #40; m_sda = 1'b1; #40;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
    i2c_start();
    for (int i = 6; i >= 0; i--) i2c_bit(a[i]);
    i2c_bit(rw);
    i2c_ack(ack);
  endtask

  task automatic check_idle(input string tag);
    chk(irq, 0, {tag, " irq"});
    chk(sw_req, 0, {tag, " sw_req"});
    chk(rel, 0, {tag, " rel"});
    chk(phase, 0, {tag, " phase"});
    chk(scl_oe, 0, {tag, " scl_oe"});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    negs(4);
    check_idle("R11 reset");
    chk(sda_oe, 0, "R11 reset sda_oe");
    rst_n = 1'b1;
    negs(4);

    // address sweep: buffered, oscillator running
    osc_run = 1'b1; buf_en = 1'b1; compat = 1'b0;
    for (int a = 0; a < 128; a++) begin
      logic hit;
      hit = (7'(a) == OWN);
      send_addr(7'(a), 1'b0, ack);
      chk(ack, hit, "R1 ack on address");
      chk(irq, hit, "R10 irq only on match");
      chk(scl_oe, 0, "R10/R7 no stretch");
      if (!hit) chk(sw_req, 0, "R10 no request");
      i2c_stop();
      chk(irq, 0, "R11 stop clears irq");
    end

    // handover matrix
    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 2; b++)
          for (int r = 0; r < 2; r++) begin
            logic buf_eff;
            string mt;
            buf_eff = (b == 1) && (c == 0);
            mt = (c == 1) ? "R9" : "R8";
            @(negedge clk);
            osc_run = logic'(o); buf_en = logic'(b); compat = logic'(c);
            txrx = 1'b0; dl = 1'b0;
            send_addr(OWN, logic'(r), ack);
            chk(ack, 1, "R1 match ack");
            chk(irq, 1, "R2 irq");
            @(negedge clk);
            if (o == 0) begin
              chk(sw_req, 1, "R2 request with irq");
              chk(rel, 0, "R3 no release without osc");
              chk(phase, 0, "R5 idle before handover");
              chk(scl_oe, 1, "R6 stretched");
              negs(20);
              chk(rel, 0, "R3 still waiting osc");
              chk(scl_oe, 1, "R6 still stretched");
              osc_run = 1'b1;
              @(negedge clk);
            end
            chk(rel, 1, "R3 release after osc");
            chk(sw_req, 0, "R4 request dropped");
            chk(irq, 1, "R4 irq kept");
            chk(phase, (r == 1) ? 2'b10 : 2'b01, "R5 phase");
            negs(2);
            if (buf_eff) begin
              chk(scl_oe, 0, "R7 buffered release");
            end else begin
              chk(scl_oe, 1, {mt, " waits txrx"});
              negs(10);
              chk(scl_oe, 1, {mt, " still waits txrx"});
              txrx = 1'b1;
              negs(3);
              if (r == 1) begin
                chk(scl_oe, 1, {mt, " read waits data"});
                negs(5);
                dl = 1'b1;
                negs(3);
              end
              chk(scl_oe, 0, {mt, " released"});
            end
            i2c_stop();
            check_idle("R11 stop");
            txrx = 1'b0; dl = 1'b0; osc_run = 1'b0;
          end

    // reset during stretch
    osc_run = 1'b0; buf_en = 1'b0; compat = 1'b0;
    @(negedge clk);
    send_addr(OWN, 1'b1, ack);
    chk(scl_oe, 1, "R6 stretched before reset");
    rst_n = 1'b0;
    negs(3);
    check_idle("R11 reset mid");
    rst_n = 1'b1;
    negs(2);
    i2c_stop();
    check_idle("R11 after reset");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule